// File: doc/BRIEF.md
# Stream-Fed Transform Engine Wrapper

This block lets a hand-written polynomial transform engine sit in a design whose other parts were produced by high-level synthesis. Toward the surrounding design it offers block-level handshake control: a start request and three indications, idle, ready and done. Toward its data neighbours it offers a ready/valid input stream and a ready/valid output stream. Toward the engine it offers a start/finish pulse pair plus a read and a write port into its own coefficient buffer.

One operation runs in four phases. After a start request the block collects a 256-coefficient polynomial from the input stream into its buffer. It then launches the engine and waits until the engine reports completion. The engine works on the buffer in place. Finally the block streams the buffer back out in index order and signals completion. Coefficients are 12 bits wide and are carried in the low bits of a 16-bit stream word.

Top module: `xform_shell`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block enters its waiting phase: blk_idle is 1, and blk_ready, blk_done, eng_start, in_tready and out_tvalid are all 0.
- R2: blk_idle is 1 only while the block waits for a start request. It is 0 throughout collection, engine run and output.
- R3: After a start request is sampled, in_tready is 1 until exactly 256 beats have been accepted, and 0 at all other times. A beat is accepted only on a rising edge with in_tvalid and in_tready both 1. Beats are stored at indices 0 to 255 in arrival order.
- R4: blk_ready is 1 for exactly one cycle, namely the cycle right after the 256th input beat is accepted.
- R5: eng_start is 1 for exactly one cycle, in the same cycle as the blk_ready pulse. out_tvalid stays 0 until the cycle after eng_done is seen high.
- R6: The output stream delivers buffer entries 0 to 255 in index order, including any engine updates. The coefficient sits in out_tdata[11:0] and out_tdata[15:12] is 0. Input bits in_tdata[15:12] are ignored.
- R7: out_tlast is 1 on output beat 255 and 0 on beats 0 to 254.
- R8: While out_tvalid is 1 and out_tready is 0, out_tvalid stays 1 and out_tdata stays unchanged in the next cycle.
- R9: blk_done is 1 for exactly one cycle, namely the cycle right after the final output beat is accepted. blk_idle is also 1 in that cycle.
- R10: blk_start has no effect outside the waiting phase. A start raised during collection, engine run or output does not change the beat count and does not begin a new collection after the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_start | input | 1 | Start request, sampled only while waiting |
| blk_idle | output | 1 | High while no operation is in progress |
| blk_ready | output | 1 | One-cycle pulse: input fully taken, next input may be prepared |
| blk_done | output | 1 | One-cycle pulse: operation complete |
| in_tdata | input | 16 | Input word, coefficient in bits 11:0 |
| in_tvalid | input | 1 | Input word valid |
| in_tready | output | 1 | Block accepts input |
| out_tdata | output | 16 | Output word, coefficient in bits 11:0, upper bits zero |
| out_tvalid | output | 1 | Output word valid |
| out_tready | input | 1 | Downstream accepts output |
| out_tlast | output | 1 | Marks output beat 255 |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_done | input | 1 | Engine finished, honoured only during the run phase |
| eng_rd_addr | input | 8 | Engine buffer read index |
| eng_rd_data | output | 12 | Buffer entry at eng_rd_addr, combinational |
| eng_wr_en | input | 1 | Engine buffer write enable, honoured only during the run phase |
| eng_wr_addr | input | 8 | Engine buffer write index |
| eng_wr_data | input | 12 | Engine buffer write value |

## Verification
The embedded assertions watch the timing that holds on every cycle. They check that blk_ready, blk_done and eng_start never stay high for two cycles, that done coincides with idle, that idle never overlaps an open stream, that stalled output words stay frozen and that the last marker appears only on a valid beat. Whether the right 256 words come out, in order and carrying the engine's updates, with the marker on the correct beat, can only be shown by the bench scenarios. The same holds for whether stray start requests during busy phases are really ignored. These scenarios drive ramp, reversed, constant and scrambled polynomials through an engine model that adds one modulo 3329, with irregular valid gaps and output backpressure, and include a reset in the middle of output.

// File: rtl/xs_pkg.sv
// Package xs_pkg
// Shared phase encoding for the transform wrapper.
// Assumes: nothing beyond the consumers importing it.
package xs_pkg;
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_FILL  = 2'd1,
        PH_CRUNCH = 2'd2,
        PH_DRAIN = 2'd3
    } xs_phase_e;
endpackage

// File: rtl/xs_buf.sv
// Module xs_buf
// Coefficient store with one write port and two combinational read ports:
// port A feeds the output stream, port B serves the engine.
// Assumes: the caller selects the single write source per cycle.
module xs_buf #(
    parameter int DEPTH = 256,
    parameter int CW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [CW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [CW-1:0] rd_b_data
);
    logic [CW-1:0] mem [DEPTH];

    // Store one coefficient per enabled cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Unregistered reads on both ports.
    always_comb begin
        rd_a_data = mem[rd_a_addr];
        rd_b_data = mem[rd_b_addr];
    end
endmodule

// File: rtl/xs_ctrl.sv
// Module xs_ctrl
// Four-phase sequencer (wait, fill, crunch, drain) with a shared index counter
// and the registered one-cycle pulses toward the enclosing design and engine.
// Assumes: in_fire/out_fire are valid&ready of the respective streams.
module xs_ctrl
    import xs_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          in_fire,
    input  logic          out_fire,
    input  logic          eng_fin,
    output xs_phase_e     phase,
    output logic [AW-1:0] idx,
    output logic          at_last,
    output logic          ready_pulse,
    output logic          done_pulse,
    output logic          launch_pulse
);
    xs_phase_e     phase_q;
    logic [AW-1:0] idx_q;
    logic          ready_q;
    logic          done_q;
    logic          launch_q;

    // Phase transitions, index stepping and pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_WAIT;
            idx_q    <= '0;
            ready_q  <= 1'b0;
            done_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            ready_q  <= 1'b0;
            done_q   <= 1'b0;
            launch_q <= 1'b0;
            unique case (phase_q)
                PH_WAIT: begin
                    if (start_req) begin
                        phase_q <= PH_FILL;
                        idx_q   <= '0;
                    end
                end
                PH_FILL: begin
                    if (in_fire) begin
                        if (idx_q == LAST) begin
                            phase_q  <= PH_CRUNCH;
                            idx_q    <= '0;
                            ready_q  <= 1'b1;
                            launch_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_CRUNCH: begin
                    if (eng_fin && !launch_q) begin
                        phase_q <= PH_DRAIN;
                        idx_q   <= '0;
                    end
                end
                PH_DRAIN: begin
                    if (out_fire) begin
                        if (idx_q == LAST) begin
                            phase_q <= PH_WAIT;
                            idx_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_WAIT;
            endcase
        end
    end

    // Expose registered state.
    always_comb begin
        phase        = phase_q;
        idx          = idx_q;
        at_last      = (idx_q == LAST);
        ready_pulse  = ready_q;
        done_pulse   = done_q;
        launch_pulse = launch_q;
    end

    // R4
    ready_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q);
    // R5
    launch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_q |=> !launch_q && phase_q == PH_CRUNCH);
    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R9
    done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> phase_q == PH_WAIT);
    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CRUNCH && !eng_fin) |=> phase_q == PH_CRUNCH);
endmodule

// File: rtl/xform_shell.sv
// Module xform_shell
// Wraps an external polynomial transform engine behind block-level
// start/idle/ready/done control and ready/valid coefficient streams.
// Assumes: the engine touches the buffer only between eng_start and eng_done.
module xform_shell
    import xs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = 12,
    parameter int SW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start,
    output logic          blk_idle,
    output logic          blk_ready,
    output logic          blk_done,
    input  logic [SW-1:0] in_tdata,
    input  logic          in_tvalid,
    output logic          in_tready,
    output logic [SW-1:0] out_tdata,
    output logic          out_tvalid,
    input  logic          out_tready,
    output logic          out_tlast,
    output logic          eng_start,
    input  logic          eng_done,
    input  logic [AW-1:0] eng_rd_addr,
    output logic [CW-1:0] eng_rd_data,
    input  logic          eng_wr_en,
    input  logic [AW-1:0] eng_wr_addr,
    input  logic [CW-1:0] eng_wr_data
);
    xs_phase_e     phase;
    logic [AW-1:0] idx;
    logic          at_last;
    logic          in_fire;
    logic          out_fire;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [CW-1:0] wr_data;
    logic [CW-1:0] drain_word;

    // Stream handshakes and block-level indications from the phase.
    always_comb begin
        blk_idle   = (phase == PH_WAIT);
        in_tready  = (phase == PH_FILL);
        out_tvalid = (phase == PH_DRAIN);
        out_tlast  = out_tvalid && at_last;
        in_fire    = in_tready && in_tvalid;
        out_fire   = out_tvalid && out_tready;
        out_tdata  = {{(SW - CW){1'b0}}, drain_word};
    end

    // Pick the buffer writer: input stream while filling, engine while crunching.
    always_comb begin
        if (phase == PH_FILL) begin
            wr_en   = in_fire;
            wr_addr = idx;
            wr_data = in_tdata[CW-1:0];
        end else begin
            wr_en   = eng_wr_en && (phase == PH_CRUNCH);
            wr_addr = eng_wr_addr;
            wr_data = eng_wr_data;
        end
    end

    xs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (blk_start),
        .in_fire      (in_fire),
        .out_fire     (out_fire),
        .eng_fin      (eng_done),
        .phase        (phase),
        .idx          (idx),
        .at_last      (at_last),
        .ready_pulse  (blk_ready),
        .done_pulse   (blk_done),
        .launch_pulse (eng_start)
    );

    xs_buf #(.DEPTH(DEPTH), .CW(CW)) u_buf (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (idx),
        .rd_a_data (drain_word),
        .rd_b_addr (eng_rd_addr),
        .rd_b_data (eng_rd_data)
    );

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata)));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_idle |-> (!in_tready && !out_tvalid));
    // R9
    done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> blk_idle);
    // R5
    ready_with_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> eng_start);
    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tlast |-> out_tvalid);
    // R3
    streams_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_tready && out_tvalid));
endmodule

// File: tb/xform_shell_test.sv
// Bench for xform_shell: a modelled engine adds 1 mod 3329 to every entry;
// frames use varied patterns, valid gaps, backpressure and stray starts.
module xform_shell_test;
    localparam int N = 256;
    localparam int Q = 3329;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_start = 1'b0;
    logic        blk_idle, blk_ready, blk_done;
    logic [15:0] in_tdata = '0;
    logic        in_tvalid = 1'b0;
    logic        in_tready;
    logic [15:0] out_tdata;
    logic        out_tvalid;
    logic        out_tready = 1'b0;
    logic        out_tlast;
    logic        eng_start;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rd_addr = '0;
    logic [11:0] eng_rd_data;
    logic        eng_wr_en = 1'b0;
    logic [7:0]  eng_wr_addr = '0;
    logic [11:0] eng_wr_data = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int src [N];

    always #10 clk = ~clk;

    xform_shell uut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
        .blk_idle(blk_idle), .blk_ready(blk_ready), .blk_done(blk_done),
        .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready),
        .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready),
        .out_tlast(out_tlast), .eng_start(eng_start), .eng_done(eng_done),
        .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data),
        .eng_wr_en(eng_wr_en), .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Engine model: in-place add 1 mod Q over all entries, then finish pulse.
    initial begin
        forever begin
            @(posedge clk);
            if (eng_start && rst_n) begin
                for (int i = 0; i < N; i++) begin
                    @(negedge clk);
                    eng_rd_addr = 8'(i);
                    #1;
                    eng_wr_addr = 8'(i);
                    eng_wr_data = 12'((int'(eng_rd_data) + 1) % Q);
                    eng_wr_en = 1'b1;
                end
                @(negedge clk);
                eng_wr_en = 1'b0;
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    function automatic int pat_val(input int p, input int i);
        case (p)
            0: return i;
            1: return Q - 1 - i;
            2: return 0;
            3: return (i * 37 + 5) % Q;
            default: return Q - 1;
        endcase
    endfunction

    // One full operation; vgap/rgap are percent idle on input valid / output ready.
    task automatic run_frame(input int p, input int vgap, input int rgap, input bit poke);
        int k;
        int j;
        bit stalled;
        logic [15:0] held;
        for (int i = 0; i < N; i++) src[i] = pat_val(p, i);
        @(negedge clk);
        chk(blk_idle == 1'b1, "R2 idle before start", blk_idle, 1);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        chk(blk_idle == 1'b0 && in_tready == 1'b1, "R3 fill opens", in_tready, 1);
        k = 0;
        while (k < N) begin
            in_tvalid = (($urandom % 100) >= vgap);
            in_tdata = {4'($urandom), 12'(src[k])};   // R6 upper bits junk
            if (poke) blk_start = 1'($urandom);        // R10
            if (!in_tready) chk(1'b0, "R3 tready during fill", in_tready, 1);
            if (blk_ready) chk(1'b0, "R4 early ready", blk_ready, 0);
            if (in_tvalid) k++;
            @(negedge clk);
        end
        in_tvalid = 1'b0;
        blk_start = 1'b0;
        chk(blk_ready == 1'b1, "R4 ready pulse", blk_ready, 1);
        chk(eng_start == 1'b1, "R5 engine launch", eng_start, 1);
        chk(in_tready == 1'b0, "R3 fill closed after 256", in_tready, 0);
        @(negedge clk);
        chk(blk_ready == 1'b0 && eng_start == 1'b0, "R4 R5 single cycle", blk_ready, 0);
        j = 0;
        stalled = 1'b0;
        held = '0;
        while (j < N) begin
            out_tready = (($urandom % 100) >= rgap);
            if (poke) blk_start = 1'($urandom);
            if (out_tvalid && eng_wr_en) chk(1'b0, "R5 valid before engine done", 1, 0);
            if (blk_idle) chk(1'b0, "R2 idle while busy", 1, 0);
            if (out_tvalid) begin
                if (stalled) chk(out_tdata == held, "R8 stalled word", out_tdata, held);
                if (out_tready) begin
                    chk(out_tdata == 16'((src[j] + 1) % Q), "R6 output word", out_tdata, (src[j] + 1) % Q);
                    chk(out_tlast == (j == N - 1), "R7 last marker", out_tlast, j == N - 1);
                    j++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    held = out_tdata;
                end
            end
            @(negedge clk);
        end
        out_tready = 1'b0;
        blk_start = 1'b0;
        chk(blk_done == 1'b1 && blk_idle == 1'b1, "R9 done with idle", blk_done, 1);
        chk(out_tvalid == 1'b0, "R9 drain closed", out_tvalid, 0);
        @(negedge clk);
        chk(blk_done == 1'b0, "R9 done single cycle", blk_done, 0);
        chk(in_tready == 1'b0, "R10 no stray restart", in_tready, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(blk_idle == 1'b1, "R1 idle in reset", blk_idle, 1);
        chk({blk_ready, blk_done, eng_start, in_tready, out_tvalid} == 5'b0, "R1 outputs low", 0, 0);
        rst_n = 1'b1;
        run_frame(0, 0, 0, 1'b0);
        run_frame(1, 30, 40, 1'b0);
        run_frame(2, 60, 10, 1'b1);
        run_frame(3, 20, 70, 1'b1);
        run_frame(4, 50, 50, 1'b0);
        // Reset in the middle of a frame after the engine has finished.
        for (int i = 0; i < N; i++) src[i] = i;
        @(negedge clk);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        in_tvalid = 1'b1;
        for (int i = 0; i < N; i++) begin
            in_tdata = 16'(i);
            @(negedge clk);
        end
        in_tvalid = 1'b0;
        while (!out_tvalid) @(negedge clk);
        out_tready = 1'b1;
        for (int i = 0; i < 10; i++) @(negedge clk);
        out_tready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(blk_idle == 1'b1 && out_tvalid == 1'b0, "R1 mid-frame reset", out_tvalid, 0);
        chk(out_tlast == 1'b0 && blk_done == 1'b0, "R1 pulses low", blk_done, 0);
        rst_n = 1'b1;
        run_frame(3, 10, 20, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule